// File: doc/BRIEF.md
# First-order delta-sigma DAC modulator

This block turns an unsigned sample word into a one-bit pulse stream whose long-run density of ones is proportional to the sample. A resistor-capacitor low-pass filter on the output pin recovers the analog level. The loop is first order. Each enabled cycle, a feedback word is added to the sample. The feedback word is the accumulator sign bit, copied into the two guard positions above the sample field, with zeros below. That sum is then added into an accumulator two bits wider than the sample. The accumulator's top bit, registered once more, is the output.

The sample width `DATA_W` (2 to 16, default 8) is a parameter. When `FULL_RANGE` is set, the input gains one extra bit so that the value 2^DATA_W drives the output permanently high, reaching the full rail. Without it, the largest code leaves one low cycle in every 2^DATA_W. The clock enable sets the modulator rate. Disabled cycles freeze the whole loop.

Top module: `dsdac_mod`

## Requirements
- R1: With a legal sample held steady, and after 3 enabled cycles of settling, `dout` is 1 on exactly `din` of every 2^DATA_W consecutive enabled cycles.
- R2: A sample of 0 keeps `dout` at 0 on every enabled cycle once settled.
- R3: With `FULL_RANGE` = 0, the all-ones sample gives 2^DATA_W - 1 ones per 2^DATA_W enabled cycles.
- R4: With `FULL_RANGE` = 1, `din` is DATA_W+1 bits wide, and the value 2^DATA_W gives a constant 1 once settled. Values 0 through 2^DATA_W are legal.
- R5: While `en` is 0, the accumulator and `dout` hold their values whatever `din` does.
- R6: Reset (`rst_n` low, asynchronous) forces `dout` to 0 and loads the accumulator with 2^DATA_W. After release with `din` = 1 and `en` high, the first 1 on `dout` follows enabled edge 2^DATA_W + 1.
- R7: After each enabled edge, `dout` equals the accumulator top bit as it stood before that edge, so there is one register between accumulator and pin.
- R8: For legal samples the accumulator never wraps. It stays in [2^DATA_W, 3*2^DATA_W).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| en | input | 1 | Clock enable; the loop advances only on edges where it is high |
| din | input | DATA_W+FULL_RANGE | Unsigned sample |
| dout | output | 1 | Pulse stream to the external filter |

## Verification
On every cycle, the embedded properties check four things. The loop and the pin freeze while disabled. The pin tracks the previous accumulator sign. The accumulator stays inside its non-wrapping window for legal samples. A zero sample, or a full-scale sample in full-range mode, cannot flip the sign bit once it has settled. Only the bench scenarios can show the density result itself: exact ones counts over whole 2^DATA_W windows for every code of an 8-bit instance and every code of a 4-bit full-range instance, with and without gaps in the enable. The scenarios also show the exact cycle of the first pulse after reset, which exposes the seed value.

// File: rtl/dsdac_pkg.sv
package dsdac_pkg;
  // guard bits above the sample field in the loop arithmetic
  localparam int unsigned GUARD_BITS = 2;

  function automatic int unsigned acc_width(input int unsigned n);
    return n + GUARD_BITS;
  endfunction

  function automatic int unsigned in_width(input int unsigned n, input bit full);
    return n + (full ? 1 : 0);
  endfunction
endpackage

// File: rtl/dsdac_delta.sv
module dsdac_delta #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IN_W   = 8,
  parameter int unsigned ACC_W  = 10
) (
  input  logic [IN_W-1:0]  din,
  input  logic             fb_msb,
  output logic [ACC_W-1:0] delta
);
  localparam int unsigned PAD_W = ACC_W - IN_W;

  logic [ACC_W-1:0] din_wide;
  logic [ACC_W-1:0] fb_word;

  // unsigned sample zero-extended into the signed loop width
  assign din_wide = {{PAD_W{1'b0}}, din};
  // sign bit copied into both guard positions: 0 or -2^DATA_W
  assign fb_word  = {{dsdac_pkg::GUARD_BITS{fb_msb}}, {DATA_W{1'b0}}};

  always_comb begin
    delta = din_wide + fb_word;
  end
endmodule

// File: rtl/dsdac_sigma.sv
module dsdac_sigma #(
  parameter int unsigned DATA_W     = 8,
  parameter bit          FULL_RANGE = 1'b0,
  parameter int unsigned IN_W       = 8,
  parameter int unsigned ACC_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IN_W-1:0]  din,
  input  logic [ACC_W-1:0] delta,
  output logic             acc_msb
);
  localparam int unsigned     PAD_W   = ACC_W - IN_W;
  localparam logic [ACC_W-1:0] ACC_LO = {2'b01, {DATA_W{1'b0}}};
  localparam logic [ACC_W-1:0] ACC_HI = {2'b11, {DATA_W{1'b0}}};

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] din_wide;
  logic             din_legal;
  logic             acc_in_win;

  // next-state: running sum of the delta terms
  always_comb begin
    acc_d = acc_q + delta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= ACC_LO;
    end else if (en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_msb = acc_q[ACC_W-1];

  // observation helpers for the properties below
  assign din_wide   = {{PAD_W{1'b0}}, din};
  assign din_legal  = (din_wide <= ACC_LO);
  assign acc_in_win = (acc_q >= ACC_LO) && (acc_q < ACC_HI);

  assert_acc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && din_legal && acc_in_win) |=> acc_in_win);

  assert_zero_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && din_wide == '0 && !acc_msb) |=> !acc_msb);

  generate
    if (FULL_RANGE) begin : g_full_chk
      assert_full_scale_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && din_wide == ACC_LO && acc_msb) |=> acc_msb);
    end
  endgenerate
endmodule

// File: rtl/dsdac_outreg.sv
module dsdac_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic acc_msb,
  output logic dout
);
  logic dout_q;
  logic dout_d;

  always_comb begin
    dout_d = acc_msb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= 1'b0;
    end else if (en) begin
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

  assert_pin_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (dout == $past(acc_msb)));

  assert_pin_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dout));

  assert_reset_low_R6: assert property (@(posedge clk)
    !rst_n |-> (dout == 1'b0));
endmodule

// File: rtl/dsdac_mod.sv
module dsdac_mod #(
  parameter int unsigned DATA_W     = 8,
  parameter bit          FULL_RANGE = 1'b0,
  localparam int unsigned IN_W      = dsdac_pkg::in_width(DATA_W, FULL_RANGE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [IN_W-1:0] din,
  output logic            dout
);
  localparam int unsigned ACC_W = dsdac_pkg::acc_width(DATA_W);

  logic [ACC_W-1:0] delta;
  logic             acc_msb;

  dsdac_delta #(
    .DATA_W (DATA_W),
    .IN_W   (IN_W),
    .ACC_W  (ACC_W)
  ) u_delta (
    .din    (din),
    .fb_msb (acc_msb),
    .delta  (delta)
  );

  dsdac_sigma #(
    .DATA_W     (DATA_W),
    .FULL_RANGE (FULL_RANGE),
    .IN_W       (IN_W),
    .ACC_W      (ACC_W)
  ) u_sigma (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .din     (din),
    .delta   (delta),
    .acc_msb (acc_msb)
  );

  dsdac_outreg u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .acc_msb (acc_msb),
    .dout    (dout)
  );
endmodule

// File: tb/dsdac_mod_tb.sv
`timescale 1ns/1ps
module dsdac_mod_tb;
  localparam int unsigned NW     = 8;
  localparam int unsigned NF     = 4;
  localparam int          WIN    = 1 << NW;
  localparam int          SETTLE = 3;

  logic       clk   = 1'b0;
  logic       rst_n = 1'b1;
  logic       en    = 1'b0;
  logic [7:0] din8  = '0;
  logic [4:0] din4  = '0;
  logic       dout8;
  logic       dout4;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  int    exp8_q[$];
  int    exp4_q[$];
  string tag8_q[$];
  string tag4_q[$];
  int    ones8 = 0;
  int    ones4 = 0;
  logic  win = 0, last = 0;
  logic  pend_en = 0, pend_win = 0, pend_last = 0;

  always #2.5 clk = ~clk;

  dsdac_mod #(.DATA_W(NW), .FULL_RANGE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din8), .dout(dout8));

  dsdac_mod #(.DATA_W(NF), .FULL_RANGE(1'b1)) u_dut_full (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din4), .dout(dout4));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: counts ones after enabled window edges, pops and compares at window end
  always @(negedge clk) begin
    if (pend_en && pend_win) begin
      ones8 += int'(dout8);
      ones4 += int'(dout4);
    end
    if (pend_en && pend_last) begin
      check(tag8_q.pop_front(), ones8, exp8_q.pop_front());
      check(tag4_q.pop_front(), ones4, exp4_q.pop_front());
      ones8 = 0;
      ones4 = 0;
    end
    pend_en   = en;
    pend_win  = win;
    pend_last = last;
  end

  // driver: one density window of WIN enabled edges, en high one cycle in `gap`
  task automatic run_window(int v8, int v4, int gap, string t8, string t4);
    int k  = 0;
    int ph = 0;
    din8 = 8'(v8);
    din4 = 5'(v4);
    exp8_q.push_back(v8);
    exp4_q.push_back(v4 * (WIN >> NF));
    tag8_q.push_back(t8);
    tag4_q.push_back(t4);
    while (k < SETTLE + WIN) begin
      logic en_now;
      @(posedge clk); #1;
      en_now = ((ph % gap) == 0);
      ph++;
      if (en_now) k++;
      en   = en_now;
      win  = en_now && (k > SETTLE);
      last = en_now && (k == SETTLE + WIN);
    end
    @(posedge clk); #1;
    en = 0; win = 0; last = 0;
  endtask

  function automatic string tag_wide(int v);
    if (v == 0)   return "R2 zero sample";
    if (v == 255) return "R3 all-ones sample R8";
    return "R1 density";
  endfunction

  function automatic string tag_full(int v);
    if (v == 16) return "R4 full-scale sample";
    if (v == 0)  return "R2 zero sample (full-range)";
    return "R1 density (full-range)";
  endfunction

  initial begin
    int first8 = 0;
    int first4 = 0;
    int changed = 0;
    logic ref8, ref4;
    #1 rst_n = 0;
    din8 = 8'd1;
    din4 = 5'd1;
    en   = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 pin low in reset (8-bit)", int'(dout8), 0);
    check("R6 pin low in reset (full-range)", int'(dout4), 0);
    @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      if (first8 == 0 && dout8) first8 = k;
      if (first4 == 0 && dout4) first4 = k;
    end
    check("R6 R7 first pulse edge (8-bit)", first8, (1 << NW) + 1);
    check("R6 R7 first pulse edge (full-range)", first4, (1 << NF) + 1);
    @(posedge clk); #1;
    en = 0;

    for (int v = 0; v < 256; v++) begin
      run_window(v, v % 17, 1, tag_wide(v), tag_full(v % 17));
    end

    run_window(1,   1,  3, "R5 gated enable, sample 1", "R5 gated enable, sample 1");
    run_window(77,  5,  3, "R5 gated enable, sample 77", "R5 gated enable, sample 5");
    run_window(200, 16, 2, "R5 gated enable, sample 200", "R5 R4 gated full scale");
    run_window(255, 0,  4, "R5 R3 gated all-ones", "R5 R2 gated zero");

    // R5: pin frozen while disabled, even as the sample moves
    din8 = 8'd128;
    din4 = 5'd8;
    @(negedge clk);
    ref8 = dout8;
    ref4 = dout4;
    for (int c = 0; c < 40; c++) begin
      @(posedge clk); #1;
      din8 = 8'(c * 37);
      din4 = 5'(c % 17);
      @(negedge clk);
      if (dout8 !== ref8 || dout4 !== ref4) changed++;
    end
    check("R5 pin stable with enable low", changed, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule